// File: doc/BRIEF.md
# Rewindable FIFO Read-Side Controller

This block runs the read side of a synchronous FIFO whose storage array sits outside it. It keeps the read pointer and compares it with a write pointer supplied by the write side. It decides each cycle which storage locations to fetch and gives their addresses to the array as registered fetch slots. It also produces the status flags for the style that is selected. In standard style, a word is fetched only when the consumer asks for one. In fall-through style, the block fills a small output stage ahead of demand, and the consumer takes words out of that stage.

A rewind command moves the read pointer back so that data still held in storage can be delivered again. The pointer goes to location zero, or to a position recorded earlier with the mark input. The write side is not touched. A strap selects the rate. At single rate, one word moves per read-clock cycle. At double rate, two words move per cycle: slot A carries the word for the rising-edge half of the cycle and slot B the word for the falling-edge half.

Top module: `rfrd_port`

## Requirements
- R1: While `rst` is high at a rising edge, `rd_ptr` becomes 0, `fetch_vld` becomes 00, `empty_n` becomes 0 and `ready_n` becomes 1. The recorded mark is cleared.
- R2: Standard style at single rate (`ddr_sel`=0, `fwft_sel`=0): a low `rd_en_n` with at least one stored word fetches the word at `rd_ptr`. The next cycle shows `fetch_vld`=01 and `fetch_addr_a`=`rd_ptr`[AW-1:0], and `rd_ptr` has grown by 1.
- R3: With `ddr_sel`=1, up to two words are fetched in one cycle, limited by the words available. Slot A (bit 0) addresses `rd_ptr` and slot B (bit 1) addresses `rd_ptr`+1. Bit 1 is never set without bit 0. The strap values `ddr_sel` and `fwft_sel` do not change outside reset.
- R4: A read request while no word is stored (`wr_ptr` equals `rd_ptr`) fetches nothing and leaves `rd_ptr` unchanged.
- R5: `empty_n` is registered. It is 1 exactly when words remain after the cycle's fetch, measured against the `wr_ptr` value sampled in that cycle.
- R6: Fall-through style (`fwft_sel`=1): an output stage holding up to 1 word (single rate) or 2 words (double rate) is filled without any request. A low `rd_en_n` consumes the words held. `ready_n` is 0 while the stage holds a word. In standard style `ready_n` stays 1.
- R7: Rewind (`rewind`=1 at a rising edge) with no mark recorded sets `rd_ptr` to 0.
- R8: `mark`=1 at a rising edge records the current `rd_ptr`. A later rewind sets `rd_ptr` to the recorded value, so the words from that point are fetched again in order.
- R9: In a rewind cycle nothing is fetched, the output stage is emptied, and the next cycle shows `empty_n`=0 and `ready_n`=1. A mark in the same cycle is ignored.
- R10: Rewind does not clear the recorded mark, so repeated rewinds return to the same position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset |
| ddr_sel | input | 1 | Rate strap: 0 single, 1 double |
| fwft_sel | input | 1 | Style strap: 0 standard, 1 fall-through |
| rd_en_n | input | 1 | Read request, active low |
| rewind | input | 1 | Rewind the read pointer |
| mark | input | 1 | Record the current read pointer |
| wr_ptr | input | AW+1 | Write pointer from the write side, with wrap bit |
| rd_ptr | output | AW+1 | Read pointer, with wrap bit |
| fetch_vld | output | 2 | Fetch slot valid bits (bit 0 slot A, bit 1 slot B) |
| fetch_addr_a | output | AW | Storage address of slot A |
| fetch_addr_b | output | AW | Storage address of slot B |
| empty_n | output | 1 | Low when no stored word is left to fetch |
| ready_n | output | 1 | Low when the fall-through stage holds a word |

## Verification
The assertions assume the following about the inputs:
- Both straps hold their values outside reset.
- `wr_ptr` never runs more than the depth ahead of `rd_ptr`.
- No more than the depth of words has been written since the rewind target was set.

The stimulus changes the straps only while reset is held. It sets the write pointer to at most 12 words on a 16-deep configuration. It rewinds only to positions whose data has not been overwritten. Under these conditions, every value the reference model predicts for pointer, slots and flags can be reached.

// File: rtl/rfrd_pkg.sv
package rfrd_pkg;
  localparam int unsigned SLOTS = 2;

  function automatic logic [1:0] min2(input logic [1:0] a, input logic [1:0] b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/rfrd_ptr.sv
module rfrd_ptr #(
  parameter int AW = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rewind,
  input  logic        mark,
  input  logic [1:0]  adv,
  output logic [AW:0] rd_ptr
);
  localparam int PW = AW + 1;

  logic [PW-1:0] mark_ptr;
  logic          mark_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr   <= '0;
      mark_ptr <= '0;
      mark_vld <= 1'b0;
    end else if (rewind) begin
      rd_ptr <= mark_vld ? mark_ptr : '0;
    end else begin
      rd_ptr <= rd_ptr + PW'(adv);
      if (mark) begin
        mark_ptr <= rd_ptr;
        mark_vld <= 1'b1;
      end
    end
  end

  // R7 / R8: a rewind lands on the recorded mark, or on zero when no mark is held
  assert_rewind_target_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rewind)) |->
      (rd_ptr == ($past(mark_vld) ? $past(mark_ptr) : PW'(0))));

  // R2: outside a rewind, the pointer moves by exactly the granted fetch count
  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rewind)) |-> (rd_ptr == $past(rd_ptr) + PW'($past(adv))));
endmodule

// File: rtl/rfrd_ctl.sv
module rfrd_ctl #(
  parameter int AW = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ddr_sel,
  input  logic        fwft_sel,
  input  logic        rd_en_n,
  input  logic        rewind,
  input  logic [AW:0] wr_ptr,
  input  logic [AW:0] rd_ptr,
  output logic [1:0]  adv,
  output logic        empty_n,
  output logic        ready_n
);
  import rfrd_pkg::*;
  localparam int PW = AW + 1;

  logic [1:0]    cap, avail_c, consume, room, held_q, held_d;
  logic [PW-1:0] avail, left;

  always_comb begin
    cap     = ddr_sel ? 2'd2 : 2'd1;
    avail   = wr_ptr - rd_ptr;
    avail_c = (avail > PW'(2)) ? 2'd2 : avail[1:0];
    consume = (!rd_en_n && fwft_sel) ? min2(held_q, cap) : 2'd0;
    if (fwft_sel) room = cap - held_q + consume;
    else          room = rd_en_n ? 2'd0 : cap;
    adv     = rewind ? 2'd0 : min2(room, avail_c);
    held_d  = fwft_sel ? (held_q - consume + adv) : 2'd0;
    left    = avail - PW'(adv);
  end

  always_ff @(posedge clk) begin
    if (rst || rewind) begin
      held_q  <= 2'd0;
      empty_n <= 1'b0;
      ready_n <= 1'b1;
    end else begin
      held_q  <= held_d;
      empty_n <= (left != '0);
      ready_n <= fwft_sel ? (held_d == 2'd0) : 1'b1;
    end
  end

  // R4: no fetch is granted while nothing is stored
  assert_no_empty_read_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr == rd_ptr) |-> (adv == 2'd0));

  // R2: single rate never moves more than one word per cycle
  assert_single_rate_R2: assert property (@(posedge clk) disable iff (rst)
    !ddr_sel |-> (adv <= 2'd1));

  // R9: flags after a rewind
  assert_rewind_flags_R9: assert property (@(posedge clk) disable iff (rst)
    rewind |=> (!empty_n && ready_n));

  // R6: ready flag only while the stage holds data
  assert_ready_held_R6: assert property (@(posedge clk) disable iff (rst)
    !ready_n |-> (fwft_sel && held_q != 2'd0));
endmodule

// File: rtl/rfrd_slots.sv
module rfrd_slots #(
  parameter int AW = 10
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [AW:0]                          rd_ptr,
  input  logic [1:0]                           adv,
  output logic [rfrd_pkg::SLOTS-1:0]           fetch_vld,
  output logic [rfrd_pkg::SLOTS-1:0][AW-1:0]   fetch_addr
);
  import rfrd_pkg::*;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        fetch_vld[i]  <= 1'b0;
        fetch_addr[i] <= '0;
      end else begin
        fetch_vld[i]  <= (adv > 2'(i));
        fetch_addr[i] <= rd_ptr[AW-1:0] + AW'(i);
      end
    end
  end

  // R3: the falling-half slot is only used together with the rising-half slot
  assert_slot_order_R3: assert property (@(posedge clk) disable iff (rst)
    fetch_vld[1] |-> fetch_vld[0]);
endmodule

// File: rtl/rfrd_port.sv
module rfrd_port #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ddr_sel,
  input  logic          fwft_sel,
  input  logic          rd_en_n,
  input  logic          rewind,
  input  logic          mark,
  input  logic [AW:0]   wr_ptr,
  output logic [AW:0]   rd_ptr,
  output logic [1:0]    fetch_vld,
  output logic [AW-1:0] fetch_addr_a,
  output logic [AW-1:0] fetch_addr_b,
  output logic          empty_n,
  output logic          ready_n
);
  import rfrd_pkg::*;

  logic [1:0]                 adv;
  logic [SLOTS-1:0][AW-1:0]   addr;

  rfrd_ctl #(.AW(AW)) u_ctl (
    .clk(clk), .rst(rst), .ddr_sel(ddr_sel), .fwft_sel(fwft_sel),
    .rd_en_n(rd_en_n), .rewind(rewind), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .adv(adv), .empty_n(empty_n), .ready_n(ready_n)
  );

  rfrd_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst(rst), .rewind(rewind), .mark(mark), .adv(adv), .rd_ptr(rd_ptr)
  );

  rfrd_slots #(.AW(AW)) u_slots (
    .clk(clk), .rst(rst), .rd_ptr(rd_ptr), .adv(adv),
    .fetch_vld(fetch_vld), .fetch_addr(addr)
  );

  assign fetch_addr_a = addr[0];
  assign fetch_addr_b = addr[1];

  // R3: straps are static outside reset
  assert_static_straps_R3: assert property (@(posedge clk) disable iff (rst)
    ($stable(ddr_sel) && $stable(fwft_sel)));
endmodule

// File: tb/rfrd_port_tb.sv
`timescale 1ns/1ps
module rfrd_port_tb;
  localparam int AW = 4;
  localparam int PW = AW + 1;
  localparam int PM = (1 << PW) - 1;
  localparam int AM = (1 << AW) - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, ddr_sel, fwft_sel, rd_en_n, rewind, mark;
  logic [AW:0] wr_ptr, rd_ptr;
  logic [1:0] fetch_vld;
  logic [AW-1:0] fetch_addr_a, fetch_addr_b;
  logic empty_n, ready_n;

  rfrd_port #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .ddr_sel(ddr_sel), .fwft_sel(fwft_sel),
    .rd_en_n(rd_en_n), .rewind(rewind), .mark(mark), .wr_ptr(wr_ptr),
    .rd_ptr(rd_ptr), .fetch_vld(fetch_vld), .fetch_addr_a(fetch_addr_a),
    .fetch_addr_b(fetch_addr_b), .empty_n(empty_n), .ready_n(ready_n)
  );

  int nchk = 0, nbad = 0, wp = 0;
  bit done = 0;
  string tag = "";
  int m_rp, m_mk, m_mv, m_held, m_en, m_rn, m_fv, m_fa, m_fb;
  int got[$];

  function automatic int val(int a);
    return (a * 37 + 11) & 255;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s %s [%s]: actual=%0d expected=%0d", req, what, tag, act, exp);
    end
  endtask

  task automatic compare();
    chk("R2", "rd_ptr", int'(rd_ptr), m_rp);
    chk("R3", "fetch_vld", int'(fetch_vld), m_fv);
    chk("R3", "fetch_addr_a", int'(fetch_addr_a), m_fa);
    chk("R3", "fetch_addr_b", int'(fetch_addr_b), m_fb);
    chk("R5", "empty_n", int'(empty_n), m_en);
    chk("R6", "ready_n", int'(ready_n), m_rn);
    if (fetch_vld[0]) got.push_back(val(int'(fetch_addr_a)));
    if (fetch_vld[1]) got.push_back(val(int'(fetch_addr_b)));
  endtask

  task automatic model_step(bit en_n, bit rw, bit mk);
    int k, cnt, f, cons, room, old;
    k = ddr_sel ? 2 : 1;
    old = m_rp;
    cnt = (wp - m_rp) & PM;
    f = 0;
    if (rw) begin
      m_rp = m_mv ? m_mk : 0;
      m_held = 0;
    end else begin
      if (fwft_sel) begin
        cons = !en_n ? ((m_held < k) ? m_held : k) : 0;
        room = k - m_held + cons;
        f = (room < cnt) ? room : cnt;
        m_held = m_held - cons + f;
      end else begin
        f = !en_n ? ((k < cnt) ? k : cnt) : 0;
        m_held = 0;
      end
      if (mk) begin m_mk = old; m_mv = 1; end
      m_rp = (m_rp + f) & PM;
    end
    m_fv = (f >= 2) ? 3 : ((f == 1) ? 1 : 0);
    m_fa = old & AM;
    m_fb = (old + 1) & AM;
    if (rw) begin
      m_en = 0; m_rn = 1;
    end else begin
      m_en = (((wp - m_rp) & PM) != 0) ? 1 : 0;
      m_rn = (fwft_sel && m_held != 0) ? 0 : 1;
    end
  endtask

  task automatic cyc(bit en_n, bit rw, bit mk);
    @(negedge clk);
    compare();
    rd_en_n = en_n; rewind = rw; mark = mk;
    wr_ptr = PW'(wp);
    model_step(en_n, rw, mk);
  endtask

  task automatic do_reset(bit d, bit f);
    @(negedge clk);
    rst = 1; ddr_sel = d; fwft_sel = f;
    rd_en_n = 1; rewind = 0; mark = 0; wp = 0; wr_ptr = '0;
    repeat (2) @(negedge clk);
    tag = "reset";
    chk("R1", "rd_ptr", int'(rd_ptr), 0);
    chk("R1", "fetch_vld", int'(fetch_vld), 0);
    chk("R1", "empty_n", int'(empty_n), 0);
    chk("R1", "ready_n", int'(ready_n), 1);
    m_rp = 0; m_mk = 0; m_mv = 0; m_held = 0; m_en = 0; m_rn = 1;
    m_fv = 0; m_fa = 0; m_fb = 0;
    rst = 0;
    model_step(1, 0, 0);
  endtask

  task automatic expect_seq(string req, int first, int n);
    chk(req, "replay count", got.size(), n);
    for (int i = 0; i < n && i < got.size(); i++)
      chk(req, "replay word", got[i], val(first + i));
  endtask

  initial begin
    rst = 1; ddr_sel = 0; fwft_sel = 0; rd_en_n = 1; rewind = 0; mark = 0; wr_ptr = '0;

    // R2 R8 R10 R4: standard style, single rate
    do_reset(0, 0);
    tag = "R2 sdr"; wp = 10; cyc(1, 0, 0);
    got.delete(); repeat (3) cyc(0, 0, 0); cyc(1, 0, 0);
    expect_seq("R2", 0, 3);
    tag = "R8 mark"; cyc(1, 0, 1);
    repeat (4) cyc(0, 0, 0);
    tag = "R9 rewind"; cyc(1, 1, 0); cyc(1, 0, 0);
    got.delete(); repeat (4) cyc(0, 0, 0); cyc(1, 0, 0);
    expect_seq("R8", 3, 4);
    tag = "R10 again"; cyc(1, 1, 0); cyc(1, 0, 0);
    got.delete(); repeat (2) cyc(0, 0, 0); cyc(1, 0, 0);
    expect_seq("R10", 3, 2);
    tag = "R9 mark+rewind"; cyc(0, 0, 0); cyc(1, 1, 1); cyc(1, 0, 0);
    got.delete(); repeat (1) cyc(0, 0, 0); cyc(1, 0, 0);
    expect_seq("R9", 3, 1);
    tag = "R4 drain"; repeat (12) cyc(0, 0, 0); cyc(1, 0, 0);
    @(negedge clk); compare();
    chk("R4", "rd_ptr after overread", int'(rd_ptr), 10);
    chk("R4", "empty_n after overread", int'(empty_n), 0);

    // R3 R7 R1: standard style, double rate, rewind without mark after reset
    do_reset(1, 0);
    tag = "R3 ddr"; wp = 9; cyc(1, 0, 0);
    got.delete(); repeat (3) cyc(0, 0, 0); cyc(1, 0, 0);
    expect_seq("R3", 0, 6);
    tag = "R7 rewind"; cyc(1, 1, 0); cyc(1, 0, 0);
    got.delete(); repeat (5) cyc(0, 0, 0); cyc(1, 0, 0);
    expect_seq("R7", 0, 9);
    tag = "R4 ddr empty"; repeat (3) cyc(0, 0, 0);
    tag = "R5 late write"; wp = 12; repeat (3) cyc(0, 0, 0); cyc(1, 0, 0);

    // R6: fall-through, single rate
    do_reset(0, 1);
    tag = "R6 fwft sdr"; wp = 5; repeat (3) cyc(1, 0, 0);
    @(negedge clk); compare();
    chk("R6", "ready_n with word staged", int'(ready_n), 0);
    rd_en_n = 1; wr_ptr = PW'(wp); model_step(1, 0, 0);
    repeat (2) cyc(0, 0, 0);
    tag = "R8 fwft mark"; cyc(1, 0, 1); repeat (2) cyc(0, 0, 0);
    tag = "R9 fwft rewind"; cyc(1, 1, 0); repeat (3) cyc(1, 0, 0);
    tag = "R6 fwft drain"; repeat (8) cyc(0, 0, 0);

    // R6 R3: fall-through, double rate
    do_reset(1, 1);
    tag = "R6 fwft ddr"; wp = 7; repeat (2) cyc(1, 0, 0);
    repeat (2) cyc(0, 0, 0);
    cyc(1, 1, 0); cyc(1, 0, 0);
    wp = 12; repeat (8) cyc(0, 0, 0); cyc(1, 0, 0);
    @(negedge clk); compare();

    done = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    #80000;
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule